// File: doc/BRIEF.md
# Masked Time-Match Alarm Controller

This block watches the running seconds, minutes, hours and date supplied by a clock core and compares them with four programmable alarm registers. The top bit of each alarm register is a mask bit; the four mask bits together select how often the alarm repeats, from every second up to once per month on a particular date. When the time agrees with the programmed fields on a 1 Hz update, an alarm flag is latched and, if enabled, an active-low interrupt output is driven.

A small host register port gives access to the alarm registers, an enable register and a flags register. Any host read or write of the flags register withdraws the interrupt at once, while the flag itself clears only after that access has finished, so a read still returns the latched flag. A power-good input marks main supply versus backup operation: in backup operation the host port is ignored and the interrupt is only raised when a separate backup-enable bit is also set. On each power-up transition both enable bits are cleared, although the flag still records any match seen meanwhile.

Top module: `alarm_match_top`

## Requirements
- R1: The mask bits are bit 7 of the alarm registers at index 1 (seconds, mask M1), 2 (minutes, M2), 3 (hours, M3) and 4 (date, M4); bits 6:0 of each are compared with bits 6:0 of the matching time input. With {M4,M3,M2,M1} = 1111 every update matches, 1110 needs seconds, 1100 needs minutes and seconds, 1000 needs hours, minutes and seconds, 0000 needs all four fields.
- R2: Any other mask pattern matches on every update, regardless of the time values.
- R3: A match on a cycle where tick1Hz is high sets the alarm flag, read as bit 6 of the flags register at index 0, from the next cycle.
- R4: A match drives irqN low from the next cycle only if the alarm-enable bit (bit 0 of the enable register at index 5) is 1; with it at 0 the flag is still set and irqN stays high.
- R5: Any host access (read or write) to index 0 while power is good drives irqN high from the cycle after the access starts.
- R6: The flag holds its value for the whole flags access, so reads during the access return it; it clears on the first clock edge after the access ends.
- R7: While powerGood is low, a match drives irqN low only when both the backup-enable bit (bit 1 of index 5) and the alarm-enable bit are 1.
- R8: A rising edge of powerGood clears both enable bits; a match during backup operation still sets the flag, which stays readable after power returns.
- R9: While powerGood is low, host writes have no effect on any register.
- R10: Time values that agree with the alarm registers do not set the flag unless tick1Hz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | High under main supply, low in backup operation |
| tick1Hz | input | 1 | One-cycle pulse per second from the clock core |
| curSec | input | 8 | Current seconds (BCD) |
| curMin | input | 8 | Current minutes (BCD) |
| curHour | input | 8 | Current hours (BCD) |
| curDate | input | 8 | Current date of month (BCD) |
| hostSel | input | 1 | Host access in progress |
| hostWr | input | 1 | Access is a write |
| hostAddr | input | 3 | Register index |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data |
| irqN | output | 1 | Active-low alarm interrupt |

## Verification
The bench builds the block with its default 8-bit registers and 3-bit index, which keeps every mask pattern within reach: all 16 mask settings are crossed with all 16 combinations of which time fields agree, and the expected flag and interrupt come from an arithmetic decode of the repeat mode. Directed sequences then cover the held flags access, enable gating under main and backup power, power-up clearing and the absence of matches between ticks.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  localparam int IDX_FLAGS  = 0;
  localparam int IDX_ALARM0 = 1;
  localparam int IDX_ENABLE = 5;
  localparam int NUM_FIELDS = 4;
  localparam int FLAG_BIT   = 6;

  typedef struct packed {
    logic regWrite;
    logic enClear;
  } dpStrobes_t;

  // need vector bit order: {date, hour, min, sec}
  function automatic logic [NUM_FIELDS-1:0] decodeMask(input logic [NUM_FIELDS-1:0] mask);
    logic [NUM_FIELDS-1:0] need;
    case (mask)
      4'b1111: need = 4'b0000;
      4'b1110: need = 4'b0001;
      4'b1100: need = 4'b0011;
      4'b1000: need = 4'b0111;
      4'b0000: need = 4'b1111;
      default: need = 4'b0000;
    endcase
    return need;
  endfunction

endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic              flagQ,
  output logic              hit,
  output logic              alarmEn,
  output logic              backupEn,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int CMP_W = DATA_W - 1;

  logic [DATA_W-1:0]     alarmReg [NUM_FIELDS];
  logic [DATA_W-1:0]     timeVal  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] maskBits;
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [NUM_FIELDS-1:0] needField;

  assign timeVal[0] = curSec;
  assign timeVal[1] = curMin;
  assign timeVal[2] = curHour;
  assign timeVal[3] = curDate;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int REG_IDX = IDX_ALARM0 + g;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmReg[g] <= '0;
      end else if (strobes.regWrite && (int'(hostAddr) == REG_IDX)) begin
        alarmReg[g] <= hostWdata;
      end
    end
    assign maskBits[g] = alarmReg[g][DATA_W-1];
    assign fieldEq[g]  = (alarmReg[g][CMP_W-1:0] == timeVal[g][CMP_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmEn  <= 1'b0;
      backupEn <= 1'b0;
    end else if (strobes.enClear) begin
      alarmEn  <= 1'b0;
      backupEn <= 1'b0;
    end else if (strobes.regWrite && (int'(hostAddr) == IDX_ENABLE)) begin
      alarmEn  <= hostWdata[0];
      backupEn <= hostWdata[1];
    end
  end

  assign needField = decodeMask(maskBits);
  assign hit       = &(fieldEq | ~needField);

  always_comb begin
    hostRdata = '0;
    if (int'(hostAddr) == IDX_FLAGS) begin
      hostRdata[FLAG_BIT] = flagQ;
    end else if (int'(hostAddr) == IDX_ENABLE) begin
      hostRdata[1:0] = {backupEn, alarmEn};
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (int'(hostAddr) == IDX_ALARM0 + i) hostRdata = alarmReg[i];
      end
    end
  end

endmodule

// File: rtl/alarm_match_ctl.sv
module alarm_match_ctl
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              tick1Hz,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hit,
  input  logic              alarmEn,
  input  logic              backupEn,
  output dpStrobes_t        strobes,
  output logic              flagQ,
  output logic              irqN
);

  logic pgQ;
  logic pendQ;
  logic irqQ;
  logic flagAccess;
  logic accessEnd;
  logic fireFlag;
  logic fireIrq;

  assign flagAccess = powerGood && hostSel && (int'(hostAddr) == IDX_FLAGS);
  assign accessEnd  = pendQ && !flagAccess;
  assign fireFlag   = tick1Hz && hit;
  assign fireIrq    = fireFlag && alarmEn && (powerGood || backupEn);

  assign strobes.regWrite = powerGood && hostSel && hostWr;
  assign strobes.enClear  = powerGood && !pgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgQ   <= 1'b0;
      pendQ <= 1'b0;
      flagQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      pgQ   <= powerGood;
      pendQ <= flagAccess;
      if (fireFlag)       flagQ <= 1'b1;
      else if (accessEnd) flagQ <= 1'b0;
      if (fireIrq)                      irqQ <= 1'b1;
      else if (flagAccess || accessEnd) irqQ <= 1'b0;
    end
  end

  assign irqN = !irqQ;

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic              tick1Hz,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irqN
);

  dpStrobes_t strobes;
  logic       hit;
  logic       alarmEn;
  logic       backupEn;
  logic       flagQ;

  alarm_match_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .tick1Hz(tick1Hz),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hit(hit), .alarmEn(alarmEn), .backupEn(backupEn),
    .strobes(strobes), .flagQ(flagQ), .irqN(irqN)
  );

  alarm_match_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .flagQ(flagQ), .hit(hit), .alarmEn(alarmEn), .backupEn(backupEn),
    .hostRdata(hostRdata)
  );

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerGood,
  input logic              tick1Hz,
  input logic              hostSel,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hit,
  input logic              alarmEn,
  input logic              backupEn,
  input logic              flagQ,
  input logic              irqN
);

  logic flagAcc;
  assign flagAcc = powerGood && hostSel && (hostAddr == '0);

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick1Hz && hit) |=> flagQ);

  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> flagQ);

  assert_irq_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagAcc && !tick1Hz) |=> irqN);

  assert_flag_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagAcc && flagQ) |=> flagQ);

  assert_backup_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!powerGood && !backupEn && irqN) |=> irqN);

  assert_enables_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |=> (!alarmEn && !backupEn));

  assert_no_tick_no_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!tick1Hz && !flagQ) |=> !flagQ);

endmodule

bind alarm_match_top alarm_match_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .powerGood(powerGood), .tick1Hz(tick1Hz),
  .hostSel(hostSel), .hostAddr(hostAddr), .hit(hit),
  .alarmEn(alarmEn), .backupEn(backupEn), .flagQ(flagQ), .irqN(irqN)
);

// File: tb/alarm_match_top_tb_top.sv
module alarm_match_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerGood = 1'b1;
  logic       tick1Hz = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0;
  logic       hostSel = 1'b0, hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       irqN;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_SEC = 8'h15, A_MIN = 8'h30, A_HR = 8'h12, A_DT = 8'h07;

  always #10 clk = ~clk;

  alarm_match_top dut_i (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .tick1Hz(tick1Hz),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irqN(irqN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #5 d = hostRdata;
    @(negedge clk);
    hostSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseTick();
    @(negedge clk);
    tick1Hz = 1'b1;
    @(negedge clk);
    tick1Hz = 1'b0;
  endtask

  task automatic setTime(input logic [3:0] eq);
    curSec  = eq[0] ? A_SEC : A_SEC + 8'h1;
    curMin  = eq[1] ? A_MIN : A_MIN + 8'h1;
    curHour = eq[2] ? A_HR  : A_HR  + 8'h1;
    curDate = eq[3] ? A_DT  : A_DT  + 8'h1;
  endtask

  function automatic logic expectFire(input logic [3:0] mask, input logic [3:0] eq);
    logic [3:0] need;
    case (mask)
      4'b1111: need = 4'b0000;
      4'b1110: need = 4'b0001;
      4'b1100: need = 4'b0011;
      4'b1000: need = 4'b0111;
      4'b0000: need = 4'b1111;
      default: need = 4'b0000;
    endcase
    return ((eq & need) == need);
  endfunction

  task automatic loadAlarm(input logic [3:0] mask);
    hostWrite(3'd1, {mask[0], A_SEC[6:0]});
    hostWrite(3'd2, {mask[1], A_MIN[6:0]});
    hostWrite(3'd3, {mask[2], A_HR[6:0]});
    hostWrite(3'd4, {mask[3], A_DT[6:0]});
  endtask

  initial begin
    logic [7:0] rd;
    logic       exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 reset irq", int'(irqN), 1);
    hostRead(3'd0, rd);
    check("R3 reset flag", int'(rd[6]), 0);
    hostRead(3'd5, rd);
    check("R8 reset enables", int'(rd[1:0]), 0);

    hostWrite(3'd5, 8'h01);
    for (int m = 0; m < 16; m++) begin
      loadAlarm(4'(m));
      for (int e = 0; e < 16; e++) begin
        setTime(4'(e));
        exp = expectFire(4'(m), 4'(e));
        pulseTick();
        check((m == 15 || m == 14 || m == 12 || m == 8 || m == 0) ? "R1 irq" : "R2 irq",
              int'(irqN), int'(!exp));
        hostRead(3'd0, rd);
        check("R3 flag", int'(rd[6]), int'(exp));
        hostRead(3'd0, rd);
        check("R6 cleared after read", int'(rd[6]), 0);
      end
    end

    // R10: matching time without tick
    loadAlarm(4'b0000);
    setTime(4'hF);
    repeat (4) @(negedge clk);
    check("R10 irq without tick", int'(irqN), 1);
    hostRead(3'd0, rd);
    check("R10 flag without tick", int'(rd[6]), 0);

    // R5/R6: held flags access
    pulseTick();
    check("R4 irq asserted", int'(irqN), 0);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = 3'd0;
    #5 check("R6 read during access", int'(hostRdata[6]), 1);
    @(negedge clk);
    check("R5 irq cleared by access", int'(irqN), 1);
    check("R6 flag held mid access", int'(hostRdata[6]), 1);
    @(negedge clk);
    check("R6 flag held late access", int'(hostRdata[6]), 1);
    hostSel = 1'b0;
    @(negedge clk);
    hostRead(3'd0, rd);
    check("R6 flag cleared at end", int'(rd[6]), 0);

    // R5 via write access
    pulseTick();
    hostWrite(3'd0, 8'hFF);
    check("R5 irq cleared by write", int'(irqN), 1);
    hostRead(3'd0, rd);
    check("R6 flag cleared by write", int'(rd[6]), 0);

    // R4: disabled interrupt
    hostWrite(3'd5, 8'h00);
    pulseTick();
    check("R4 irq gated off", int'(irqN), 1);
    hostRead(3'd0, rd);
    check("R4 flag still set", int'(rd[6]), 1);

    // R7: backup, only alarm enable
    hostWrite(3'd5, 8'h01);
    @(negedge clk); powerGood = 1'b0;
    pulseTick();
    check("R7 irq needs backup enable", int'(irqN), 1);
    // R9: write ignored in backup
    hostWrite(3'd1, 8'h00);
    @(negedge clk); powerGood = 1'b1;
    @(negedge clk);
    hostRead(3'd1, rd);
    check("R9 write ignored", int'(rd), int'({1'b0, A_SEC[6:0]}));
    hostRead(3'd0, rd);
    check("R8 flag kept over power-up", int'(rd[6]), 1);
    hostRead(3'd5, rd);
    check("R8 enables cleared", int'(rd[1:0]), 0);

    // R7: backup with both enables
    hostWrite(3'd5, 8'h03);
    @(negedge clk); powerGood = 1'b0;
    pulseTick();
    check("R7 irq in backup", int'(irqN), 0);
    @(negedge clk); powerGood = 1'b1;
    @(negedge clk);
    hostRead(3'd5, rd);
    check("R8 enables cleared again", int'(rd[1:0]), 0);
    hostRead(3'd0, rd);
    check("R8 flag after wake", int'(rd[6]), 1);
    check("R5 irq cleared after wake read", int'(irqN), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule